// File: doc/BRIEF.md
# Sprite Line-Buffer Priority Compositor

This block merges a stream of sprite pixels into a one-line buffer during the scan line before that line is shown. Each buffer entry is 10 bits wide: a 2-bit depth in bits [9:8] and an 8-bit colour index in bits [7:0]. Sprites arrive in ascending attribute-memory order. At equal depth, the sprite with the lowest attribute address must appear in front. The block therefore refuses to overwrite an entry that already holds an opaque pixel at the same depth. A pixel at a greater depth always replaces the entry, a pixel at a lesser depth is dropped, and colour index 0 is transparent and is never stored.

A control state machine has three states. In `ST_IDLE` the block takes one pixel per clock. `ST_DRAIN` is entered from `ST_IDLE` when `clear_start` is seen. It waits until the merge pipeline has no pending write, then moves to `ST_CLEAR`. `ST_CLEAR` writes an all-zero entry to one address per clock, from 0 upward. After the last address it returns to `ST_IDLE`.

Each merge is a read followed by a write. The read is registered and the write happens one clock later. A write in flight is forwarded to a read of the same address, so back-to-back pixels at the same x merge exactly as if they had been applied one at a time. A separate registered read port lets the display side fetch any entry.

Top module: `sprite_lb_compositor`

## Requirements
- R1: After reset the state machine is in `ST_IDLE` and `pix_ready` is 1.
- R2: When `clear_start` is seen in `ST_IDLE` with no pixel pending, `pix_ready` is 0 for exactly LINE_W+1 clocks: one in `ST_DRAIN` and LINE_W in `ST_CLEAR`. Afterwards every entry reads 0 (depth 0, colour 0), including entries that held pixels before the clear.
- R3: A pixel with colour index 0 never changes the buffer, at any depth.
- R4: An opaque pixel landing on a transparent entry stores {depth, colour}, with depth in bits [9:8] and colour in bits [7:0].
- R5: An opaque pixel whose depth equals the depth of an opaque stored entry leaves that entry unchanged, so the earlier sprite stays in front.
- R6: An opaque pixel whose depth is strictly greater than the stored depth replaces the entry.
- R7: An opaque pixel whose depth is strictly less than the stored depth leaves the entry unchanged.
- R8: One pixel is accepted on every clock in which `pix_valid` and `pix_ready` are both 1. Consecutive pixels at the same or different x give the same buffer contents as applying them one at a time in arrival order.
- R9: `rd_entry` shows the entry addressed by `rd_addr` one clock after `rd_addr` is presented. It reflects every merge write completed before that clock.
- R10: A pixel presented while `pix_ready` is 0 is ignored and does not change the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_start | input | 1 | Request to wipe the line buffer |
| pix_valid | input | 1 | A sprite pixel is presented |
| pix_x | input | X_W | Pixel x position (buffer address) |
| pix_color | input | 8 | Pixel colour index; 0 means transparent |
| pix_depth | input | 2 | Pixel depth; a larger value is nearer the front |
| pix_ready | output | 1 | Block accepts a pixel this clock (high only in `ST_IDLE`) |
| rd_addr | input | X_W | Display read address |
| rd_entry | output | 10 | Entry at `rd_addr`: depth in [9:8], colour in [7:0] |

## Verification
The bench aims pixels of equal depth at one entry. A design that let later sprites win would show the second colour there. It also sends back-to-back pixels to one address with mixed depths and transparent pixels; with a missing forward path, the stale read would let a shallower or equal-depth pixel overwrite the entry. Pixels are driven while a clear is running at an address the clear has already passed, which exposes any acceptance outside `ST_IDLE`. The length of the not-ready window and a full readback after the clear catch a counter that stops early or skips an address.

// File: rtl/sprite_lb_pkg.sv
package sprite_lb_pkg;

    typedef struct packed {
        logic [1:0] depth;
        logic [7:0] color;
    } lb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_CLEAR = 2'd2
    } lb_state_e;

endpackage

// File: rtl/sprite_lb_rule.sv
module sprite_lb_rule
    import sprite_lb_pkg::*;
(
    input  lb_entry_t incoming,
    input  lb_entry_t stored,
    output logic      take
);
    logic opaque_in;
    logic stored_empty;
    logic deeper;
    logic same_depth;

    always_comb begin
        opaque_in    = (incoming.color != 8'd0);
        stored_empty = (stored.color == 8'd0);
        deeper       = (incoming.depth > stored.depth);
        same_depth   = (incoming.depth == stored.depth);
        // Earlier sprite keeps the pixel at equal depth; only a deeper one displaces it.
        take = opaque_in && (deeper || (same_depth && stored_empty));
    end
endmodule

// File: rtl/sprite_lb_mem.sv
module sprite_lb_mem
    import sprite_lb_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int X_W    = $clog2(LINE_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_we,
    input  logic [X_W-1:0] clr_addr,
    input  logic           mrg_we,
    input  logic [X_W-1:0] mrg_addr,
    input  lb_entry_t      mrg_data,
    input  logic [X_W-1:0] lk_addr,
    output lb_entry_t      lk_data,
    input  logic [X_W-1:0] rd_addr,
    output logic [9:0]     rd_data
);
    lb_entry_t store [LINE_W];

    always_ff @(posedge clk) begin
        if (clr_we) begin
            store[clr_addr] <= '0;
        end else if (mrg_we) begin
            store[mrg_addr] <= mrg_data;
        end
        // Forward a write in flight so a following pixel at the same x sees it.
        if (mrg_we && (mrg_addr == lk_addr)) begin
            lk_data <= mrg_data;
        end else begin
            lk_data <= store[lk_addr];
        end
        rd_data <= store[rd_addr];
    end

    assert_clear_merge_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_we && mrg_we));

    assert_no_transparent_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mrg_we |-> (mrg_data.color != 8'd0));

    assert_depth_never_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mrg_we |-> (mrg_data.depth >= store[mrg_addr].depth));

    assert_equal_depth_keeps_front_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mrg_we && (mrg_data.depth == store[mrg_addr].depth)) |-> (store[mrg_addr].color == 8'd0));
endmodule

// File: rtl/sprite_lb_ctrl.sv
module sprite_lb_ctrl
    import sprite_lb_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int X_W    = $clog2(LINE_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_start,
    input  logic           s1_valid,
    output lb_state_e      state,
    output logic           pix_ready,
    output logic           clr_we,
    output logic [X_W-1:0] clr_addr
);
    localparam logic [X_W-1:0] LAST_ADDR = X_W'(LINE_W - 1);

    lb_state_e      state_nx;
    logic [X_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= (state == ST_CLEAR) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (clear_start)        state_nx = ST_DRAIN;
            ST_DRAIN: if (!s1_valid)          state_nx = ST_CLEAR;
            ST_CLEAR: if (cnt == LAST_ADDR)   state_nx = ST_IDLE;
            default:                          state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        pix_ready = 1'b0;
        clr_we    = 1'b0;
        clr_addr  = cnt;
        unique case (state)
            ST_IDLE:  pix_ready = 1'b1;
            ST_DRAIN: pix_ready = 1'b0;
            ST_CLEAR: clr_we    = 1'b1;
            default:  pix_ready = 1'b0;
        endcase
    end

    assert_clear_after_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |-> !s1_valid);

    assert_clear_ends_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR && cnt == LAST_ADDR) |=> (state == ST_IDLE));
endmodule

// File: rtl/sprite_lb_compositor.sv
module sprite_lb_compositor
    import sprite_lb_pkg::*;
#(
    parameter int LINE_W = 64,
    parameter int X_W    = $clog2(LINE_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear_start,
    input  logic           pix_valid,
    input  logic [X_W-1:0] pix_x,
    input  logic [7:0]     pix_color,
    input  logic [1:0]     pix_depth,
    output logic           pix_ready,
    input  logic [X_W-1:0] rd_addr,
    output logic [9:0]     rd_entry
);
    lb_state_e      state;
    logic           accept;
    logic           s1_valid;
    logic [X_W-1:0] s1_x;
    lb_entry_t      s1_pix;
    lb_entry_t      lk_data;
    logic           take;
    logic           mrg_we;
    logic           clr_we;
    logic [X_W-1:0] clr_addr;

    assign accept = pix_valid && pix_ready;
    assign mrg_we = s1_valid && take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x     <= '0;
            s1_pix   <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_x   <= pix_x;
                s1_pix <= '{depth: pix_depth, color: pix_color};
            end
        end
    end

    sprite_lb_ctrl #(.LINE_W(LINE_W), .X_W(X_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_start (clear_start),
        .s1_valid    (s1_valid),
        .state       (state),
        .pix_ready   (pix_ready),
        .clr_we      (clr_we),
        .clr_addr    (clr_addr)
    );

    sprite_lb_rule u_rule (
        .incoming (s1_pix),
        .stored   (lk_data),
        .take     (take)
    );

    sprite_lb_mem #(.LINE_W(LINE_W), .X_W(X_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (clr_we),
        .clr_addr (clr_addr),
        .mrg_we   (mrg_we),
        .mrg_addr (s1_x),
        .mrg_data (s1_pix),
        .lk_addr  (pix_x),
        .lk_data  (lk_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_entry)
    );

    assert_accept_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> ($past(state) == ST_IDLE));
endmodule

// File: tb/sprite_lb_compositor_bench.sv
module sprite_lb_compositor_bench;
    localparam int LW = 64;
    localparam int XW = $clog2(LW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_start = 1'b0;
    logic          pix_valid = 1'b0;
    logic [XW-1:0] pix_x = '0;
    logic [7:0]    pix_color = '0;
    logic [1:0]    pix_depth = '0;
    logic          pix_ready;
    logic [XW-1:0] rd_addr = '0;
    logic [9:0]    rd_entry;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [9:0] model [LW];
    logic [9:0] exp_q [$];
    string      tag_q [$];
    logic       rd_issue = 1'b0;
    logic       issue_d  = 1'b0;

    always #10 clk = ~clk;

    sprite_lb_compositor #(.LINE_W(LW)) u_sprite_lb_compositor (
        .clk(clk), .rst_n(rst_n), .clear_start(clear_start),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_color(pix_color),
        .pix_depth(pix_depth), .pix_ready(pix_ready),
        .rd_addr(rd_addr), .rd_entry(rd_entry)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare read-port results against the scoreboard queue.
    always @(posedge clk) issue_d <= rd_issue;
    always @(negedge clk) begin
        if (issue_d && exp_q.size() > 0) begin
            check(tag_q.pop_front(), {22'd0, rd_entry}, {22'd0, exp_q.pop_front()});
        end
    end

    // Driver: present one pixel for one clock and update the reference model.
    task automatic push_pixel(input int x, input logic [7:0] c, input logic [1:0] d);
        logic [9:0] old;
        old = model[x];
        check("R8 ready while streaming", {31'd0, pix_ready}, 32'd1);
        pix_valid = 1'b1; pix_x = XW'(x); pix_color = c; pix_depth = d;
        if (c != 8'd0 && (d > old[9:8] || (d == old[9:8] && old[7:0] == 8'd0)))
            model[x] = {d, c};
        @(negedge clk);
    endtask

    task automatic end_stream();
        pix_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_entry(input int x, input string tag);
        rd_addr = XW'(x);
        rd_issue = 1'b1;
        exp_q.push_back(model[x]);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_issue = 1'b0;
    endtask

    task automatic do_clear(input bit inject);
        int low;
        low = 0;
        clear_start = 1'b1;
        @(negedge clk);
        clear_start = 1'b0;
        while (!pix_ready && low < 4 * LW) begin
            low++;
            // R10: pixels offered while not ready at an address already cleared
            if (inject && low == 10) begin
                pix_valid = 1'b1; pix_x = '0; pix_color = 8'h99; pix_depth = 2'd3;
            end
            if (inject && low == 14) pix_valid = 1'b0;
            @(negedge clk);
        end
        pix_valid = 1'b0;
        check("R2 not-ready window", low, LW + 1);
        for (int i = 0; i < LW; i++) model[i] = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R8 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", {31'd0, pix_ready}, 32'd1);

        do_clear(1'b0);
        for (int i = 0; i < LW; i++) expect_entry(i, "R2 cleared entry");

        // Single-pixel priority cases at x=5, spaced apart
        push_pixel(5, 8'h12, 2'd1); end_stream();
        expect_entry(5, "R4 opaque into empty");
        push_pixel(5, 8'h34, 2'd1); end_stream();
        expect_entry(5, "R5 equal depth keeps earlier");
        push_pixel(5, 8'h56, 2'd2); end_stream();
        expect_entry(5, "R6 deeper replaces");
        push_pixel(5, 8'h77, 2'd1); end_stream();
        expect_entry(5, "R7 shallower dropped");
        push_pixel(5, 8'h00, 2'd3); end_stream();
        expect_entry(5, "R3 transparent over opaque");
        push_pixel(6, 8'h00, 2'd3); end_stream();
        expect_entry(6, "R3 transparent over empty");
        expect_entry(5, "R9 depth in [9:8] colour in [7:0]");
        check("R9 field layout", {22'd0, model[5]}, 32'h256);

        // Back-to-back bursts
        push_pixel(10, 8'h20, 2'd0);
        push_pixel(10, 8'h21, 2'd0);
        push_pixel(10, 8'h22, 2'd3);
        push_pixel(10, 8'h23, 2'd3);
        push_pixel(10, 8'h24, 2'd2);
        push_pixel(11, 8'h30, 2'd1);
        push_pixel(11, 8'h00, 2'd3);
        push_pixel(11, 8'h31, 2'd2);
        push_pixel(12, 8'h40, 2'd1);
        push_pixel(13, 8'h41, 2'd1);
        push_pixel(12, 8'h42, 2'd1);
        push_pixel(13, 8'h43, 2'd2);
        push_pixel(12, 8'h44, 2'd2);
        end_stream();
        expect_entry(10, "R8 burst same x");
        expect_entry(11, "R8 burst with transparent");
        expect_entry(12, "R8 interleaved x 12");
        expect_entry(13, "R8 interleaved x 13");

        // Clear wipes existing pixels; pixels offered during clear are ignored
        do_clear(1'b1);
        expect_entry(0, "R10 pixel during clear ignored");
        expect_entry(5, "R2 clear wipes pixel");
        expect_entry(10, "R2 clear wipes burst");
        check("R1 ready after clear", {31'd0, pix_ready}, 32'd1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule